// File: doc/BRIEF.md
# Prescaled Timer/Counter with Atomic 16-bit Access

This block is a timer/counter peripheral that hangs off an 8-bit register bus. Its count register can run as a 16-bit counter or as an 8-bit counter in its low byte. The count source is either an instruction-rate tick, which is the system clock divided by four, or rising edges on an external pin after a synchronizer. A power-of-two prescaler can sit between the source and the counter. A sticky overflow flag records every rollover, and software clears it.

Software sees four byte registers: control, count low, count high and flag. The high byte goes through a one-byte holding buffer, so a 16-bit value moves over the 8-bit bus in one piece. Reading the low byte freezes the matching high byte for a later read. Writing the high byte stages it, and the following low-byte write commits both halves together. To shorten the period, software preloads the counter with the full range minus the wanted divisor, for example 65536 − 10000 = 55536 to divide by 10000.

Top module: `prescaled_tick_timer`

## Requirements
- R1: After reset, the control register reads 0x00, both count bytes read 0x00, the flag register reads 0x00 and `ovf_flag` is 0.
- R2: The control register is at address 0. Bit 7 is run, bit 6 is narrow mode (1 = 8-bit), bit 5 is external source, bit 3 is prescaler bypass and bits 2:0 are the divider select. Bit 4 always reads back as 0.
- R3: With the external source bit at 0 and bypass at 1, a running counter advances by exactly one per four system clocks.
- R4: With the external source bit at 1, each rising edge on `ext_clk_in` advances the counter by one, and a level held high counts only once.
- R5: With bypass at 0, the counter advances once per 2^(sel+1) source ticks, where sel is the divider select, so the range is 2 to 256.
- R6: In 16-bit mode the count wraps from 0xFFFF to 0x0000 and sets the flag.
- R7: In 8-bit mode the low byte wraps from 0xFF to 0x00 and sets the flag, and the high byte stays unchanged.
- R8: The flag (address 3, bit 0) stays set until a write to address 3 with bit 0 at 0. A write with bit 0 at 1 has no effect. A rollover in the same cycle as a clear wins.
- R9: Reading count low (address 1) copies the live high byte into the buffer. Reading count high (address 2) returns the buffer.
- R10: Writing count high only loads the buffer. Writing count low loads the low byte and moves the buffer into the count high byte in the same cycle.
- R11: While run is 0 the count holds. The prescaler restarts from zero while stopped and on every count-low write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the strobe |
| ext_clk_in | input | 1 | Asynchronous external count input |
| ovf_flag | output | 1 | Sticky rollover flag |

## Verification
The instruction-rate source is run for exact windows of 40, 80 and 2048 clocks, using bypass and divider selects 0, 2 and 7. The resulting counts (10, 10, 2, 2) separate a wrong source rate from a wrong divider and from a prescaler that keeps a stale partial count. Preloads close to the top show the 16-bit wrap apart from the 8-bit wrap, where the high byte must stay frozen. External pulses and a long held level show edge counting apart from level counting. Sequences of reads and writes across a carry show that the high byte comes from a snapshot and not from the live counter, and that a high-byte write stays staged until the low byte is written.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
    localparam int BYTE_W      = 8;
    localparam int CNT_W       = 16;
    localparam int PS_SEL_W    = 3;
    localparam int PS_CNT_W    = 1 << PS_SEL_W;
    localparam int INSTR_DIV_W = 2;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_CNT_LO = 2'd1,
        REG_CNT_HI = 2'd2,
        REG_FLAG   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic                run;
        logic                narrow;
        logic                ext_src;
        logic                spare;
        logic                no_presc;
        logic [PS_SEL_W-1:0] div_sel;
    } ctrl_t;

    // terminal prescaler value for a divide of 2^(sel+1)
    function automatic logic [PS_CNT_W-1:0] presc_last(input logic [PS_SEL_W-1:0] sel);
        logic [PS_CNT_W-1:0] ones;
        int                  sh;
        ones = '1;
        sh   = PS_CNT_W - 1 - int'(sel);
        return ones >> sh;
    endfunction
endpackage

// File: rtl/ptt_tick_source.sv
module ptt_tick_source #(
    parameter int INSTR_DIV_W = ptt_pkg::INSTR_DIV_W,
    parameter int SYNC_STAGES = ptt_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_sel,
    input  logic ext_in,
    output logic instr_tick,
    output logic ext_edge,
    output logic src_tick
);
    logic [INSTR_DIV_W-1:0] phase_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_q + 1'b1;
    end

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= ext_in;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign instr_tick = &phase_q;
    assign ext_edge   = sync_q[SYNC_STAGES-1] & ~prev_q;
    assign src_tick   = ext_sel ? ext_edge : instr_tick;
endmodule

// File: rtl/ptt_prescaler.sv
module ptt_prescaler #(
    parameter int PS_SEL_W = ptt_pkg::PS_SEL_W,
    parameter int PS_CNT_W = ptt_pkg::PS_CNT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                bypass,
    input  logic [PS_SEL_W-1:0] sel,
    input  logic                src_tick,
    output logic                cnt_tick
);
    logic [PS_CNT_W-1:0] presc_q;
    logic [PS_CNT_W-1:0] last;
    logic                hit;

    assign last = ptt_pkg::presc_last(sel);
    assign hit  = src_tick && (presc_q == last);

    always_ff @(posedge clk) begin
        if (rst || clr)    presc_q <= '0;
        else if (hit)      presc_q <= '0;
        else if (src_tick) presc_q <= presc_q + 1'b1;
    end

    assign cnt_tick = bypass ? src_tick : hit;
endmodule

// File: rtl/ptt_counter.sv
module ptt_counter #(
    parameter int CNT_W  = ptt_pkg::CNT_W,
    parameter int BYTE_W = ptt_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              narrow,
    input  logic              cnt_tick,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_lo,
    input  logic [CNT_W-BYTE_W-1:0] load_hi,
    output logic [CNT_W-1:0]  count,
    output logic              wrap
);
    localparam int HI_W = CNT_W - BYTE_W;

    logic [CNT_W-1:0]  count_q;
    logic [BYTE_W-1:0] lo_inc;
    logic              step;

    assign step   = run && cnt_tick && !load;
    assign lo_inc = count_q[BYTE_W-1:0] + 1'b1;
    assign wrap   = step && (narrow ? (&count_q[BYTE_W-1:0]) : (&count_q));

    always_ff @(posedge clk) begin
        if (rst)       count_q <= '0;
        else if (load) count_q <= {load_hi, load_lo};
        else if (step) begin
            if (narrow) count_q <= {count_q[CNT_W-1:BYTE_W], lo_inc};
            else        count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;

    logic [HI_W-1:0] unused_hi_w;
    assign unused_hi_w = '0;
endmodule

// File: rtl/prescaled_tick_timer.sv
module prescaled_tick_timer
    import ptt_pkg::*;
#(
    parameter int CNT_W = ptt_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ext_clk_in,
    output logic              ovf_flag
);
    localparam int HI_W = CNT_W - BYTE_W;

    ctrl_t             ctrl_q;
    ctrl_t             wr_ctrl_val;
    logic [HI_W-1:0]   hi_buf_q;
    logic              flag_q;
    logic [CNT_W-1:0]  count;
    logic              wrap;
    logic              instr_tick, ext_edge, src_tick, cnt_tick;
    logic              wr_ctrl, wr_lo, wr_hi, wr_flag, rd_lo;
    reg_sel_e          sel;

    assign sel     = reg_sel_e'(bus_addr);
    assign wr_ctrl = bus_wr && (sel == REG_CTRL);
    assign wr_lo   = bus_wr && (sel == REG_CNT_LO);
    assign wr_hi   = bus_wr && (sel == REG_CNT_HI);
    assign wr_flag = bus_wr && (sel == REG_FLAG);
    assign rd_lo   = bus_rd && !bus_wr && (sel == REG_CNT_LO);

    always_comb begin
        wr_ctrl_val       = ctrl_t'(bus_wdata);
        wr_ctrl_val.spare = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wr_ctrl_val;
    end

    ptt_tick_source u_src (
        .clk        (clk),
        .rst        (rst),
        .ext_sel    (ctrl_q.ext_src),
        .ext_in     (ext_clk_in),
        .instr_tick (instr_tick),
        .ext_edge   (ext_edge),
        .src_tick   (src_tick)
    );

    ptt_prescaler u_presc (
        .clk      (clk),
        .rst      (rst),
        .clr      (!ctrl_q.run || wr_lo),
        .bypass   (ctrl_q.no_presc),
        .sel      (ctrl_q.div_sel),
        .src_tick (src_tick),
        .cnt_tick (cnt_tick)
    );

    ptt_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl_q.run),
        .narrow   (ctrl_q.narrow),
        .cnt_tick (cnt_tick),
        .load     (wr_lo),
        .load_lo  (bus_wdata),
        .load_hi  (hi_buf_q),
        .count    (count),
        .wrap     (wrap)
    );

    // shared high-byte holding buffer
    always_ff @(posedge clk) begin
        if (rst)        hi_buf_q <= '0;
        else if (wr_hi) hi_buf_q <= bus_wdata[HI_W-1:0];
        else if (rd_lo) hi_buf_q <= count[CNT_W-1:BYTE_W];
    end

    // rollover has priority over a software clear
    always_ff @(posedge clk) begin
        if (rst)                          flag_q <= 1'b0;
        else if (wrap)                    flag_q <= 1'b1;
        else if (wr_flag && !bus_wdata[0]) flag_q <= 1'b0;
    end

    always_comb begin
        unique case (sel)
            REG_CTRL:   bus_rdata = ctrl_q;
            REG_CNT_LO: bus_rdata = count[BYTE_W-1:0];
            REG_CNT_HI: bus_rdata = hi_buf_q[BYTE_W-1:0];
            default:    bus_rdata = {{(BYTE_W-1){1'b0}}, flag_q};
        endcase
    end

    assign ovf_flag = flag_q;
endmodule

// File: rtl/ptt_checker.sv
module ptt_checker (
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [1:0]  bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        ovf_flag,
    input logic        run,
    input logic        narrow,
    input logic        cnt_tick,
    input logic        instr_tick,
    input logic        ext_edge,
    input logic [15:0] count,
    input logic [7:0]  hi_buf
);
    logic clr_wr, lo_wr, hi_wr, lo_rd;
    assign clr_wr = bus_wr && (bus_addr == 2'd3) && !bus_wdata[0];
    assign lo_wr  = bus_wr && (bus_addr == 2'd1);
    assign hi_wr  = bus_wr && (bus_addr == 2'd2);
    assign lo_rd  = bus_rd && !bus_wr && (bus_addr == 2'd1);

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) ovf_flag && !clr_wr |=> ovf_flag); // R8
    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (rst) run && !narrow && cnt_tick && !lo_wr && (count == 16'hFFFF) |=> ovf_flag && (count == 16'h0000)); // R6
    AST_NARROW_HIGH_HELD: assert property (@(posedge clk) disable iff (rst) narrow && !lo_wr |=> $stable(count[15:8])); // R7
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst) !run && !lo_wr |=> $stable(count)); // R11
    AST_SNAPSHOT: assert property (@(posedge clk) disable iff (rst) lo_rd |=> hi_buf == $past(count[15:8])); // R9
    AST_STAGE_HIGH: assert property (@(posedge clk) disable iff (rst) hi_wr |=> hi_buf == $past(bus_wdata)); // R10
    AST_INSTR_SINGLE: assert property (@(posedge clk) disable iff (rst) instr_tick |=> !instr_tick); // R3
    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst) ext_edge |=> !ext_edge); // R4
endmodule

bind prescaled_tick_timer ptt_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .ovf_flag   (ovf_flag),
    .run        (ctrl_q.run),
    .narrow     (ctrl_q.narrow),
    .cnt_tick   (cnt_tick),
    .instr_tick (instr_tick),
    .ext_edge   (ext_edge),
    .count      (count),
    .hi_buf     (hi_buf_q)
);

// File: tb/prescaled_tick_timer_tb_top.sv
`timescale 1ns/100ps
module prescaled_tick_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_clk_in = 1'b0;
    logic       ovf_flag;

    int total = 0;
    int bad   = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    prescaled_tick_timer dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_clk_in(ext_clk_in), .ovf_flag(ovf_flag)
    );

    // monitor: compares each read against the scoreboard queue
    always @(negedge clk) begin
        if (bus_rd && exp_q.size() > 0) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (bus_rdata !== e) begin
                bad++;
                $display("FAIL %s: actual=%02h expected=%02h", t, bus_rdata, e);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic preload(input logic [7:0] hi, input logic [7:0] lo);
        wr(2'd2, hi);
        wr(2'd1, lo);
    endtask

    task automatic pulse();
        ext_clk_in = 1'b1; idle(3);
        ext_clk_in = 1'b0; idle(3);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(2);
        // R1 reset state
        rd(2'd0, 8'h00, "R1 ctrl");
        rd(2'd1, 8'h00, "R1 low");
        rd(2'd2, 8'h00, "R1 high");
        rd(2'd3, 8'h00, "R1 flag");
        total++;
        if (ovf_flag !== 1'b0) begin bad++; $display("FAIL R1 pin: actual=%b expected=0", ovf_flag); end

        // R2 control readback, bit 4 reads 0
        wr(2'd0, 8'h5F);
        rd(2'd0, 8'h4F, "R2 ctrl readback");
        wr(2'd0, 8'h00);

        // R3 instruction rate with bypass: 40 clocks -> 10
        preload(8'h00, 8'h00);
        wr(2'd0, 8'h88); idle(39); wr(2'd0, 8'h08);
        rd(2'd1, 8'h0A, "R3 low");
        rd(2'd2, 8'h00, "R3 high");
        rd(2'd3, 8'h00, "R3 no flag");

        // R5 divide by 2: 80 clocks -> 10
        preload(8'h00, 8'h00);
        wr(2'd0, 8'h80); idle(79); wr(2'd0, 8'h00);
        rd(2'd1, 8'h0A, "R5 div2");
        // R5 divide by 8: 80 clocks -> 2
        preload(8'h00, 8'h00);
        wr(2'd0, 8'h82); idle(79); wr(2'd0, 8'h02);
        rd(2'd1, 8'h02, "R5 div8");
        // R5 divide by 256: 2048 clocks -> 2
        preload(8'h00, 8'h00);
        wr(2'd0, 8'h87); idle(2047); wr(2'd0, 8'h07);
        rd(2'd1, 8'h02, "R5 div256");

        // R11 stopped counter holds
        wr(2'd0, 8'h08); idle(100);
        rd(2'd1, 8'h02, "R11 hold");

        // R6 16-bit wrap
        preload(8'hFF, 8'hFE);
        wr(2'd0, 8'h88); idle(39); wr(2'd0, 8'h08);
        rd(2'd1, 8'h08, "R6 low");
        rd(2'd2, 8'h00, "R6 high");
        rd(2'd3, 8'h01, "R6 flag");

        // R8 sticky flag, write 1 ignored, write 0 clears
        idle(20);
        rd(2'd3, 8'h01, "R8 sticky");
        wr(2'd3, 8'h01);
        rd(2'd3, 8'h01, "R8 write1 ignored");
        wr(2'd3, 8'h00);
        rd(2'd3, 8'h00, "R8 cleared");
        wr(2'd3, 8'h01);
        rd(2'd3, 8'h00, "R8 write1 no set");

        // R7 8-bit wrap, high byte frozen
        preload(8'h12, 8'hFC);
        wr(2'd0, 8'hC8); idle(39); wr(2'd0, 8'h48);
        rd(2'd1, 8'h06, "R7 low");
        rd(2'd2, 8'h12, "R7 high");
        rd(2'd3, 8'h01, "R7 flag");
        wr(2'd3, 8'h00);

        // R4 external edges
        wr(2'd0, 8'hA8);
        preload(8'h00, 8'h00);
        for (int i = 0; i < 5; i++) pulse();
        idle(8);
        rd(2'd1, 8'h05, "R4 five edges");
        ext_clk_in = 1'b1; idle(20); ext_clk_in = 1'b0; idle(8);
        rd(2'd1, 8'h06, "R4 held level once");

        // R9 snapshot across a carry
        preload(8'h01, 8'hFE);
        rd(2'd1, 8'hFE, "R9 low");
        for (int i = 0; i < 4; i++) pulse();
        idle(8);
        rd(2'd2, 8'h01, "R9 snapshot high");
        rd(2'd1, 8'h02, "R9 new low");
        rd(2'd2, 8'h02, "R9 new high");

        // R10 staged high write
        wr(2'd2, 8'hAB);
        rd(2'd1, 8'h02, "R10 low after stage");
        rd(2'd2, 8'h02, "R10 live high untouched");
        preload(8'h55, 8'h66);
        rd(2'd1, 8'h66, "R10 low loaded");
        rd(2'd2, 8'h55, "R10 high committed");

        idle(4);
        finish_run();
    end
endmodule